// File: doc/BRIEF.md
# Quad-Mode Pseudo-Static RAM Burst Reader

This block reads bursts of bytes from an external pseudo-static RAM that is already running in four-wire quad mode. A host presents a 24-bit byte address and a byte count, and once the request is taken the block runs the whole read on the memory pins. It lowers chip select and spends one setup interface clock with the serial clock held low. It then sends the fast-read command as two nibbles and the address as six nibbles. Next it releases the data wires for a fixed number of wait clocks. After that it collects nibbles, pairs them into bytes and presents each byte with a one-cycle strobe.

The serial clock runs at half the system clock. Each interface clock is two system cycles, the first with the serial clock low and the second with it high. The block changes its outgoing nibble at the start of the low half and samples the incoming nibble at the end of the high half. The burst is linear: it does not restart at the memory's 1024-byte page edges. Chip select stays low until the requested count is reached. After that, chip select is held high for a minimum gap before the next request is accepted.

Top module: `qpi_burst_reader`

## Requirements
- R1: Out of reset, and whenever no read is in progress, `csN` is 1, `sclk` is 0, `sioOe` is 0, `reqReady` is 1, and `rdValid` and `rdDone` are 0.
- R2: A request is taken on a rising clock edge where `reqValid` and `reqReady` are both 1, and `csN` goes to 0 in the next cycle. `reqReady` stays 0 from then until the read and its gap have finished. A `reqValid` pulse during that time has no effect on any pin or on the data returned.
- R3: Each interface clock lasts two system cycles with `sclk` low then high. The first interface clock after `csN` falls is a setup clock with `sclk` held low. The next two carry the command byte `CMD` (default 0xEB) on `sioOut`, high nibble first.
- R4: The six interface clocks after the command carry the 24-bit address on `sioOut`, most significant nibble first.
- R5: `sioOe` is 1 exactly during the eight command and address interface clocks and 0 at all other times, including while `csN` is 1.
- R6: After the address the block waits `DUMMY_CLKS` interface clocks (default 6). The first data nibble is sampled at the end of the high half of the next interface clock. Byte k is therefore presented in cycle 22 + 2·DUMMY_CLKS + 4k after the accepting edge, counting that edge's next cycle as 0.
- R7: Two consecutive sampled nibbles form one byte, the first one sampled being bits 7:4. Each byte appears on `rdData` with `rdValid` high for exactly one cycle.
- R8: A burst returns exactly `reqLen` bytes from consecutive addresses, and `csN` stays 0 for the whole burst even when it crosses a 1024-byte page boundary.
- R9: After the last byte `csN` is high for at least 2·`CS_GAP` system cycles before it may fall again.
- R10: `sclk` is never 1 while `csN` is 1.
- R11: `rdDone` is 1 for one cycle, in the same cycle as the last byte's `rdValid`, and never otherwise.
- R12: A `reqLen` of 0 requests 2^`LEN_W` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the interface clock rate |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Block can take a request |
| reqAddr | input | 24 | Start byte address |
| reqLen | input | LEN_W | Byte count, 0 meaning 2^LEN_W |
| rdData | output | 8 | Returned byte |
| rdValid | output | 1 | One-cycle strobe for rdData |
| rdDone | output | 1 | Marks the last byte of a burst |
| csN | output | 1 | Memory chip select, active low |
| sclk | output | 1 | Memory serial clock |
| sioOut | output | 4 | Nibble driven towards the memory |
| sioOe | output | 1 | Enable for the sioOut drivers |
| sioIn | input | 4 | Nibble received from the memory |

## Verification
The bench builds the block with `LEN_W` = 4 and keeps the default command, six wait clocks and a `CS_GAP` of 2. The small count width lets a zero-length request run its full 16-byte wrap in a short burst. A start address a few bytes below a 1024-byte boundary carries a burst across a page edge. Requests issued as soon as `reqReady` returns show that the chip-select gap is at its minimum, and a request pulse in the middle of a burst tests that busy-time requests are ignored.

// File: rtl/qpi_rd_pkg.sv
package qpi_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_GAP
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;   // load command and address into the shifter
    logic shiftOut;   // advance outgoing nibble
    logic capture;    // sample incoming nibble
    logic byteEnd;    // this capture completes a byte
  } dpStrobe_t;

endpackage

// File: rtl/qpi_rd_ctrl.sv
module qpi_rd_ctrl
  import qpi_rd_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int DUMMY_CLKS = 6,
  parameter int CS_GAP     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqLen,
  output logic             reqReady,
  output logic             csN,
  output logic             sclk,
  output logic             sioOe,
  output logic             rdDone,
  output dpStrobe_t        strobe
);

  localparam int ADDR_NIBS = 6;
  localparam int SLOT_MAX  = (DUMMY_CLKS > ADDR_NIBS) ? DUMMY_CLKS : ADDR_NIBS;
  localparam int SLOT_W    = $clog2(SLOT_MAX + 1);
  localparam int GAP_CYC   = 2 * CS_GAP;
  localparam int GAP_W     = $clog2(GAP_CYC + 2);

  rdState_t         state;
  logic             phase;
  logic             nibSel;
  logic [SLOT_W-1:0] slotCnt;
  logic [LEN_W-1:0] byteLeft;
  logic [GAP_W-1:0] gapCnt;
  logic             rdDoneQ;
  logic             accept;

  assign accept = reqValid && (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= 1'b0;
      nibSel   <= 1'b0;
      slotCnt  <= '0;
      byteLeft <= '0;
      gapCnt   <= '0;
      rdDoneQ  <= 1'b0;
    end else begin
      rdDoneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_SETUP;
            byteLeft <= reqLen;
            phase    <= 1'b0;
            slotCnt  <= '0;
          end
        end
        ST_GAP: begin
          if (gapCnt == '0) state <= ST_IDLE;
          else gapCnt <= gapCnt - 1'b1;
        end
        default: begin
          phase <= ~phase;
          if (phase) begin
            slotCnt <= slotCnt + 1'b1;
            case (state)
              ST_SETUP: begin
                state   <= ST_CMD;
                slotCnt <= '0;
              end
              ST_CMD: begin
                if (slotCnt == SLOT_W'(1)) begin
                  state   <= ST_ADDR;
                  slotCnt <= '0;
                end
              end
              ST_ADDR: begin
                if (slotCnt == SLOT_W'(ADDR_NIBS - 1)) begin
                  state   <= ST_DUMMY;
                  slotCnt <= '0;
                end
              end
              ST_DUMMY: begin
                if (slotCnt == SLOT_W'(DUMMY_CLKS - 1)) begin
                  state   <= ST_DATA;
                  slotCnt <= '0;
                  nibSel  <= 1'b0;
                end
              end
              ST_DATA: begin
                slotCnt <= '0;
                nibSel  <= ~nibSel;
                if (nibSel) begin
                  byteLeft <= byteLeft - 1'b1;
                  if (byteLeft == LEN_W'(1)) begin
                    state   <= ST_GAP;
                    gapCnt  <= GAP_W'(GAP_CYC - 1);
                    rdDoneQ <= 1'b1;
                    phase   <= 1'b0;
                  end
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign csN      = (state == ST_IDLE) || (state == ST_GAP);
  assign sclk     = phase && (state inside {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA});
  assign sioOe    = (state == ST_CMD) || (state == ST_ADDR);
  assign rdDone   = rdDoneQ;

  assign strobe.loadAddr = accept;
  assign strobe.shiftOut = phase && ((state == ST_CMD) || (state == ST_ADDR));
  assign strobe.capture  = phase && (state == ST_DATA);
  assign strobe.byteEnd  = nibSel;

  // checker state: consecutive cycles with chip select high
  logic [GAP_W-1:0] csHighCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csHighCnt <= GAP_W'(GAP_CYC + 1);
    else if (!csN) csHighCnt <= '0;
    else if (csHighCnt < GAP_W'(GAP_CYC + 1)) csHighCnt <= csHighCnt + 1'b1;
  end

  p_accept_selects_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !csN);

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !reqReady);

  p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (csHighCnt >= GAP_W'(GAP_CYC)));

endmodule

// File: rtl/qpi_rd_dpath.sv
module qpi_rd_dpath
  import qpi_rd_pkg::*;
#(
  parameter logic [7:0] CMD = 8'hEB
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strobe,
  input  logic [23:0] reqAddr,
  input  logic [3:0]  sioIn,
  output logic [3:0]  sioOut,
  output logic [7:0]  rdData,
  output logic        rdValid
);

  logic [31:0] shiftReg;
  logic [3:0]  hiNib;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      hiNib    <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      rdValid <= 1'b0;
      if (strobe.loadAddr) shiftReg <= {CMD, reqAddr};
      else if (strobe.shiftOut) shiftReg <= {shiftReg[27:0], 4'h0};
      if (strobe.capture) begin
        if (strobe.byteEnd) begin
          rdData  <= {hiNib, sioIn};
          rdValid <= 1'b1;
        end else begin
          hiNib <= sioIn;
        end
      end
    end
  end

  assign sioOut = shiftReg[31:28];

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/qpi_burst_reader.sv
module qpi_burst_reader
  import qpi_rd_pkg::*;
#(
  parameter int         LEN_W      = 8,
  parameter int         DUMMY_CLKS = 6,
  parameter int         CS_GAP     = 2,
  parameter logic [7:0] CMD        = 8'hEB
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [23:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             rdDone,
  output logic             csN,
  output logic             sclk,
  output logic [3:0]       sioOut,
  output logic             sioOe,
  input  logic [3:0]       sioIn
);

  dpStrobe_t strobe;

  qpi_rd_ctrl #(
    .LEN_W(LEN_W), .DUMMY_CLKS(DUMMY_CLKS), .CS_GAP(CS_GAP)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .reqReady(reqReady), .csN(csN), .sclk(sclk), .sioOe(sioOe),
    .rdDone(rdDone), .strobe(strobe)
  );

  qpi_rd_dpath #(.CMD(CMD)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .sioIn(sioIn), .sioOut(sioOut), .rdData(rdData), .rdValid(rdValid)
  );

  p_sclk_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  p_bus_released_r5: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sioOe);

  p_done_with_byte_r11: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> rdValid);

  p_no_cs_mid_burst_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdDone) |-> !csN);

endmodule

// File: tb/test_qpi_burst_reader.sv
module test_qpi_burst_reader;

  localparam int LEN_W      = 4;
  localparam int DUMMY_CLKS = 6;
  localparam int CS_GAP     = 2;
  localparam logic [7:0] CMD = 8'hEB;
  localparam int DATA_NIB0  = 8 + DUMMY_CLKS;  // rising edges before data

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [23:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [7:0] rdData;
  logic rdValid, rdDone, csN, sclk, sioOe;
  logic [3:0] sioOut;
  logic [3:0] sioIn = 4'h0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  qpi_burst_reader #(
    .LEN_W(LEN_W), .DUMMY_CLKS(DUMMY_CLKS), .CS_GAP(CS_GAP), .CMD(CMD)
  ) i_qpi_burst_reader (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .rdData(rdData), .rdValid(rdValid),
    .rdDone(rdDone), .csN(csN), .sclk(sclk), .sioOut(sioOut), .sioOe(sioOe),
    .sioIn(sioIn)
  );

  function automatic logic [7:0] memByte(logic [23:0] ad);
    return ad[7:0] ^ ad[15:8] ^ {ad[3:0], ad[23:20]} ^ 8'h3C;
  endfunction

  // behavioural memory device
  int devRise = 0;
  logic [23:0] devAddr = '0;
  always @(posedge csN) devRise = 0;
  always @(posedge sclk) begin
    if (!csN) begin
      devRise = devRise + 1;
      if (devRise >= 3 && devRise <= 8) devAddr = {devAddr[19:0], sioOut};
    end
  end
  always @(negedge sclk) begin
    if (!csN && devRise >= DATA_NIB0) begin
      int j;
      logic [7:0] b;
      j = devRise - DATA_NIB0;
      b = memByte(devAddr + 24'(j / 2));
      #1 sioIn = (j % 2 == 1) ? b[3:0] : b[7:4];
    end
  end

  task automatic chk(string req, string nm, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic expectIdle();
    chk("R1", "csN", 8'(csN), 8'd1);
    chk("R1", "sclk", 8'(sclk), 8'd0);
    chk("R1", "sioOe", 8'(sioOe), 8'd0);
    chk("R1", "reqReady", 8'(reqReady), 8'd1);
    chk("R1", "rdValid", 8'(rdValid), 8'd0);
    chk("R1", "rdDone", 8'(rdDone), 8'd0);
  endtask

  // runs one burst; caller is at a negedge in an idle cycle
  task automatic runRead(logic [23:0] a, int len, bit poke);
    int leff, tLast, tEnd, seen;
    leff  = (len == 0) ? (1 << LEN_W) : len;
    tLast = 2 * (8 + DUMMY_CLKS + 2 * leff) + 1;
    tEnd  = tLast + 2 * CS_GAP;
    seen  = 0;
    expectIdle();
    reqValid = 1'b1;
    reqAddr  = a;
    reqLen   = LEN_W'(len);
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr  = '0;
    for (int t = 0; t <= tEnd; t++) begin
      int slot, ph, k, v0;
      logic expValid;
      slot = t / 2;
      ph   = t % 2;
      v0   = 22 + 2 * DUMMY_CLKS;
      if (t <= tLast) begin
        chk("R8", "csN", 8'(csN), 8'd0);
        chk("R3", "sclk", 8'(sclk), (slot >= 1 && ph == 1) ? 8'd1 : 8'd0);
        chk("R5", "sioOe", 8'(sioOe), (slot >= 1 && slot <= 8) ? 8'd1 : 8'd0);
        if (slot == 1) chk("R3", "cmdHi", 8'(sioOut), 8'(CMD[7:4]));
        if (slot == 2) chk("R3", "cmdLo", 8'(sioOut), 8'(CMD[3:0]));
        if (slot >= 3 && slot <= 8)
          chk("R4", "addrNib", 8'(sioOut), 8'((a >> (20 - 4 * (slot - 3))) & 24'hF));
      end else begin
        chk("R9", "csN", 8'(csN), 8'd1);
        chk("R10", "sclk", 8'(sclk), 8'd0);
        chk("R5", "sioOe", 8'(sioOe), 8'd0);
      end
      chk("R2", "reqReady", 8'(reqReady), 8'd0);
      k = (t - v0) / 4;
      expValid = (t >= v0) && ((t - v0) % 4 == 0) && (k < leff);
      chk("R6", "rdValid", 8'(rdValid), 8'(expValid));
      if (expValid) begin
        chk("R7", "rdData", rdData, memByte(a + 24'(k)));
        seen++;
      end
      chk("R11", "rdDone", 8'(rdDone), 8'(expValid && (k == leff - 1)));
      if (poke && (t == 20 || t == 40)) begin
        reqValid = 1'b1;       // R2: must be ignored while busy
        reqAddr  = ~a;
        reqLen   = '1;
      end else begin
        reqValid = 1'b0;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
    chk((len == 0) ? "R12" : "R8", "byteCount", 8'(seen), 8'(leff));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expectIdle();                      // R1 during reset
    rstN = 1'b1;
    repeat (4) begin
      @(negedge clk);
      expectIdle();                    // R1 after reset
    end
    runRead(24'h123456, 3, 1'b0);
    runRead(24'h0003FC, 8, 1'b0);      // R8 page crossing
    runRead(24'hABCDEF, 1, 1'b1);      // R2 poke while busy
    runRead(24'h000010, 0, 1'b0);      // R12 zero means full count
    runRead(24'h7FFBFE, 5, 1'b1);      // R8 page crossing again, back to back
    repeat (3) begin
      expectIdle();
      @(negedge clk);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule